// File: doc/BRIEF.md
# UART Receive Line-Condition Monitor

This block follows a UART receive deserializer. It takes one strobe per received character together with the character's data and its parity, framing and noise flags. It also takes a strobe per bit period that carries the sampled line level. From these inputs it keeps four 16-bit receive error counters. It recognises BREAK characters and counts a long break only once. It measures runs of consecutive ones as IDLE sequences and counts them against a programmable maximum.

When the idle count reaches that maximum, or when a BREAK arrives, the block closes the currently open receive buffer. It then raises single-cycle interrupt pulses, each gated by its own enable input. Software can preset the counters, but only while the channel is disabled. Oversampling, deserialization and buffer storage are handled elsewhere.

Top module: `uart_rx_linemon`

## Requirements
- R1: While reset is asserted and right after it, all four counters read 0, and `buf_close`, `rx_irq`, `brk_irq` and `br_flag` are 0.
- R2: While `chan_en`=1, a `char_stb` carrying a non-BREAK character adds 1 to each counter whose flag is set. `char_perr` adds to `cnt_par`, `char_ferr` to `cnt_frm` and `char_noise` to `cnt_nos`. The new values appear one cycle after the strobe.
- R3: Each counter is 16 bits wide and steps from 0xFFFF to 0x0000.
- R4: `cnt_wr_en` loads `cnt_wr_data` into the counter picked by `cnt_wr_sel` (0 parity, 1 framing, 2 noise, 3 break) only while `chan_en`=0. While `chan_en`=1 the write has no effect.
- R5: A BREAK is a strobed character whose data is all zero and which has `char_ferr` set. A BREAK adds 1 to `cnt_brk` only: parity, framing and noise counters stay unchanged. One cycle later `brk_irq` pulses for one cycle if `brk_irq_en`=1.
- R6: After a BREAK, further BREAK characters neither count nor interrupt until a `line_bit_stb` reports `line_level`=1.
- R7: A counted BREAK while `buf_open`=1 pulses `buf_close` and sets `br_flag`, and also pulses `rx_irq` if `rx_irq_en`=1. `br_flag` clears on the next non-BREAK character.
- R8: An IDLE sequence is L consecutive `line_bit_stb` with `line_level`=1, where L = 1 + (8 if `cfg_data8` else 7) + `cfg_par_en` + (2 if `cfg_stop2` else 1) + `cfg_addr_bit`, clamped to 9..13. A 0 level restarts the run.
- R9: Each IDLE sequence increments an idle count that stops at `max_idl`. The sequence that makes it equal to `max_idl` pulses `buf_close` (and `rx_irq` if enabled) when `buf_open`=1. `max_idl`=0 disables this.
- R10: Any `char_stb` clears both the idle count and the current ones run.
- R11: With `chan_en`=0 the character and bit strobes have no effect. Each interrupt pulse only appears when its enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_addr_bit | input | 1 | Extra address bit per character |
| max_idl | input | 16 | Idle sequences before buffer close, 0 disables |
| rx_irq_en | input | 1 | Enable for the RX interrupt pulse |
| brk_irq_en | input | 1 | Enable for the BRK interrupt pulse |
| buf_open | input | 1 | A receive buffer is currently open |
| char_stb | input | 1 | One-cycle strobe per received character |
| char_data | input | 8 | Received character data |
| char_perr | input | 1 | Parity error on this character |
| char_ferr | input | 1 | Framing error on this character |
| char_noise | input | 1 | Noise detected on this character |
| line_bit_stb | input | 1 | One-cycle strobe per bit period |
| line_level | input | 1 | Sampled line level with `line_bit_stb` |
| cnt_wr_en | input | 1 | Counter preload write |
| cnt_wr_sel | input | 2 | Preload target: 0 par, 1 frm, 2 noise, 3 break |
| cnt_wr_data | input | 16 | Preload value |
| buf_close | output | 1 | Pulse: close the open buffer |
| rx_irq | output | 1 | Pulse: RX interrupt |
| brk_irq | output | 1 | Pulse: BRK interrupt |
| br_flag | output | 1 | Buffer closed by a BREAK |
| cnt_par | output | 16 | Parity error count |
| cnt_frm | output | 16 | Framing error count |
| cnt_nos | output | 16 | Noise error count |
| cnt_brk | output | 16 | Break count |

## Verification
A stuck or wrong break arming state shows one cycle after the next BREAK strobe, either as a missing `brk_irq` pulse or as an extra increment of `cnt_brk`. A wrong ones-run length or a wrong idle count shows as a `buf_close` pulse on the wrong bit strobe. The pulse comes one cycle after the strobe concerned, so off-by-one errors in the run length are visible at once. A mis-routed counter increment or an accepted preload appears on the counter outputs on the cycle after the strobe or write.

// File: rtl/linemon_pkg.sv
package linemon_pkg;
   localparam int NUM_ERR_CNT = 4;
   localparam int SEL_W       = $clog2(NUM_ERR_CNT);
   // counter slots; the preload select decodes these
   localparam int IDX_PAR = 0;
   localparam int IDX_FRM = 1;
   localparam int IDX_NOS = 2;
   localparam int IDX_BRK = 3;
   localparam int IDLE_MIN = 9;
   localparam int IDLE_MAX = 13;

   function automatic logic [3:0] idle_bits(input logic data8, input logic par_en,
                                            input logic stop2, input logic addr_bit);
      int n;
      n = 1 + (data8 ? 8 : 7) + (par_en ? 1 : 0) + (stop2 ? 2 : 1) + (addr_bit ? 1 : 0);
      if (n < IDLE_MIN) n = IDLE_MIN;
      if (n > IDLE_MAX) n = IDLE_MAX;
      return 4'(n);
   endfunction
endpackage

// File: rtl/linemon_errcnt.sv
module linemon_errcnt #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nxt;

   generate
      if (W < 2) begin : g_bad_w
         $error("linemon_errcnt: W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         always_comb cnt_nxt = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         always_comb cnt_nxt = cnt_q + 1'b1;
         assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i && !load_i && cnt_q == '1) |=> (cnt_q == '0));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (inc_i)  cnt_q <= cnt_nxt;
   end

   assign cnt_o = cnt_q;

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/linemon_idle.sv
module linemon_idle #(
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          char_stb_i,
   input  logic          bit_stb_i,
   input  logic          bit_lvl_i,
   input  logic [3:0]    len_i,
   input  logic [IW-1:0] max_i,
   input  logic          buf_open_i,
   output logic          close_o
);
   logic [3:0]    run_q;
   logic [IW-1:0] icnt_q;
   logic          seq_done;
   logic          at_cap;
   logic          hit;

   generate
      if (IW < 1) begin : g_bad_iw
         $error("linemon_idle: IW must be at least 1");
      end
   endgenerate

   always_comb begin
      seq_done = en_i && !char_stb_i && bit_stb_i && bit_lvl_i && ((run_q + 4'd1) >= len_i);
      at_cap   = (max_i == '0) || (icnt_q >= max_i);
      hit      = seq_done && !at_cap && ((icnt_q + 1'b1) == max_i);
      close_o  = hit && buf_open_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i || char_stb_i) begin
         run_q  <= '0;
         icnt_q <= '0;
      end else if (bit_stb_i) begin
         if (!bit_lvl_i || seq_done) run_q <= '0;
         else                        run_q <= run_q + 4'd1;
         if (seq_done && !at_cap)    icnt_q <= icnt_q + 1'b1;
      end
   end

   assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < 4'd13);
   assert_zero_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && bit_stb_i && !bit_lvl_i) |=> (run_q == '0));
endmodule

// File: rtl/linemon_brk.sv
module linemon_brk #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          char_stb_i,
   input  logic [DW-1:0] data_i,
   input  logic          ferr_i,
   input  logic          bit_stb_i,
   input  logic          bit_lvl_i,
   output logic          brk_char_o,
   output logic          brk_evt_o
);
   logic armed_q;

   generate
      if (DW < 5) begin : g_bad_dw
         $error("linemon_brk: DW must be at least 5");
      end
   endgenerate

   always_comb begin
      brk_char_o = en_i && char_stb_i && (data_i == '0) && ferr_i;
      brk_evt_o  = brk_char_o && armed_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       armed_q <= 1'b1;
      else if (brk_evt_o)               armed_q <= 1'b0;
      else if (bit_stb_i && bit_lvl_i)  armed_q <= 1'b1;
   end

   assert_brk_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt_o |=> !brk_evt_o);
endmodule

// File: rtl/uart_rx_linemon.sv
module uart_rx_linemon
   import linemon_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int DATA_W       = 8,
   parameter int IDLE_W       = 16,
   parameter bit CNT_SATURATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              cfg_data8,
   input  logic              cfg_par_en,
   input  logic              cfg_stop2,
   input  logic              cfg_addr_bit,
   input  logic [IDLE_W-1:0] max_idl,
   input  logic              rx_irq_en,
   input  logic              brk_irq_en,
   input  logic              buf_open,
   input  logic              char_stb,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_perr,
   input  logic              char_ferr,
   input  logic              char_noise,
   input  logic              line_bit_stb,
   input  logic              line_level,
   input  logic              cnt_wr_en,
   input  logic [SEL_W-1:0]  cnt_wr_sel,
   input  logic [CNT_W-1:0]  cnt_wr_data,
   output logic              buf_close,
   output logic              rx_irq,
   output logic              brk_irq,
   output logic              br_flag,
   output logic [CNT_W-1:0]  cnt_par,
   output logic [CNT_W-1:0]  cnt_frm,
   output logic [CNT_W-1:0]  cnt_nos,
   output logic [CNT_W-1:0]  cnt_brk
);
   logic [3:0]             idle_len;
   logic                   idle_close;
   logic                   brk_char;
   logic                   brk_evt;
   logic                   good_char;
   logic                   close_req;
   logic                   load_ok;
   logic [NUM_ERR_CNT-1:0] inc_vec;
   logic [CNT_W-1:0]       cnt_arr [NUM_ERR_CNT];

   always_comb begin
      idle_len  = idle_bits(cfg_data8, cfg_par_en, cfg_stop2, cfg_addr_bit);
      good_char = chan_en && char_stb && !brk_char;
      load_ok   = cnt_wr_en && !chan_en;
      inc_vec          = '0;
      inc_vec[IDX_PAR] = good_char && char_perr;
      inc_vec[IDX_FRM] = good_char && char_ferr;
      inc_vec[IDX_NOS] = good_char && char_noise;
      inc_vec[IDX_BRK] = brk_evt;
      close_req = idle_close || (brk_evt && buf_open);
   end

   linemon_idle #(.IW(IDLE_W)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (chan_en),
      .char_stb_i (char_stb),
      .bit_stb_i  (line_bit_stb),
      .bit_lvl_i  (line_level),
      .len_i      (idle_len),
      .max_i      (max_idl),
      .buf_open_i (buf_open),
      .close_o    (idle_close)
   );

   linemon_brk #(.DW(DATA_W)) u_brk (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (chan_en),
      .char_stb_i (char_stb),
      .data_i     (char_data),
      .ferr_i     (char_ferr),
      .bit_stb_i  (line_bit_stb),
      .bit_lvl_i  (line_level),
      .brk_char_o (brk_char),
      .brk_evt_o  (brk_evt)
   );

   generate
      for (genvar g = 0; g < NUM_ERR_CNT; g++) begin : g_cnt
         linemon_errcnt #(.W(CNT_W), .SATURATE(CNT_SATURATE)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (inc_vec[g]),
            .load_i     (load_ok && (cnt_wr_sel == SEL_W'(g))),
            .load_val_i (cnt_wr_data),
            .cnt_o      (cnt_arr[g])
         );
      end
   endgenerate

   assign cnt_par = cnt_arr[IDX_PAR];
   assign cnt_frm = cnt_arr[IDX_FRM];
   assign cnt_nos = cnt_arr[IDX_NOS];
   assign cnt_brk = cnt_arr[IDX_BRK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_close <= 1'b0;
         rx_irq    <= 1'b0;
         brk_irq   <= 1'b0;
         br_flag   <= 1'b0;
      end else begin
         buf_close <= close_req;
         rx_irq    <= close_req && rx_irq_en;
         brk_irq   <= brk_evt && brk_irq_en;
         if (brk_evt && buf_open) br_flag <= 1'b1;
         else if (good_char)      br_flag <= 1'b0;
      end
   end

   assert_quiet_counters_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !char_stb) |=> ($stable(cnt_par) && $stable(cnt_frm)
                                  && $stable(cnt_nos) && $stable(cnt_brk)));
   assert_rx_with_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> buf_close);
   assert_br_needs_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(br_flag) |-> $past(buf_open));
   assert_brk_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      brk_irq |-> $past(brk_irq_en));
endmodule

// File: tb/test_uart_rx_linemon.sv
module test_uart_rx_linemon;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        cfg_data8 = 1'b0, cfg_par_en = 1'b0, cfg_stop2 = 1'b0, cfg_addr_bit = 1'b0;
   logic [15:0] max_idl = '0;
   logic        rx_irq_en = 1'b0, brk_irq_en = 1'b0, buf_open = 1'b0;
   logic        char_stb = 1'b0;
   logic [7:0]  char_data = '0;
   logic        char_perr = 1'b0, char_ferr = 1'b0, char_noise = 1'b0;
   logic        line_bit_stb = 1'b0, line_level = 1'b1;
   logic        cnt_wr_en = 1'b0;
   logic [1:0]  cnt_wr_sel = '0;
   logic [15:0] cnt_wr_data = '0;
   logic        buf_close, rx_irq, brk_irq, br_flag;
   logic [15:0] cnt_par, cnt_frm, cnt_nos, cnt_brk;

   int n_chk = 0;
   int n_bad = 0;
   int n_close = 0;
   int n_rx = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_linemon i_uart_rx_linemon (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_char(input logic [7:0] d, input logic p, input logic f, input logic n);
      @(negedge clk);
      char_stb = 1'b1; char_data = d; char_perr = p; char_ferr = f; char_noise = n;
      @(negedge clk);
      char_stb = 1'b0; char_perr = 1'b0; char_ferr = 1'b0; char_noise = 1'b0;
   endtask

   task automatic send_bit(input logic lvl);
      @(negedge clk);
      line_bit_stb = 1'b1; line_level = lvl;
      @(negedge clk);
      line_bit_stb = 1'b0; line_level = 1'b1;
      if (buf_close) n_close++;
      if (rx_irq)    n_rx++;
   endtask

   task automatic ones(input int n);
      n_close = 0; n_rx = 0;
      for (int i = 0; i < n; i++) send_bit(1'b1);
   endtask

   task automatic preload(input logic [1:0] sel, input logic [15:0] val);
      @(negedge clk);
      cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = val;
      @(negedge clk);
      cnt_wr_en = 1'b0;
   endtask

   task automatic clear_all();
      chan_en = 1'b0;
      for (int s = 0; s < 4; s++) preload(2'(s), 16'h0000);
      chan_en = 1'b1;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 cnt_par", cnt_par, 0);
      chk("R1 cnt_brk", cnt_brk, 0);
      chk("R1 pulses", {12'd0, buf_close, rx_irq, brk_irq, br_flag}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cnt_frm after", cnt_frm, 0);
      chk("R1 cnt_nos after", cnt_nos, 0);
   endtask

   task automatic t_err_counts();
      clear_all();
      send_char(8'h41, 1'b1, 1'b0, 1'b0);
      chk("R2 parity", cnt_par, 1);
      send_char(8'h42, 1'b0, 1'b1, 1'b1);
      chk("R2 framing", cnt_frm, 1);
      chk("R2 noise", cnt_nos, 1);
      send_char(8'h43, 1'b1, 1'b1, 1'b1);
      chk("R2 all par", cnt_par, 2);
      chk("R2 all frm", cnt_frm, 2);
      chk("R2 all nos", cnt_nos, 2);
      chk("R2 no brk", cnt_brk, 0);
   endtask

   task automatic t_wrap();
      chan_en = 1'b0;
      preload(2'd0, 16'hFFFF);
      preload(2'd2, 16'hFFFE);
      chan_en = 1'b1;
      send_char(8'h10, 1'b1, 1'b0, 1'b1);
      chk("R3 parity wrap", cnt_par, 16'h0000);
      chk("R3 noise step", cnt_nos, 16'hFFFF);
      send_char(8'h10, 1'b0, 1'b0, 1'b1);
      chk("R3 noise wrap", cnt_nos, 16'h0000);
   endtask

   task automatic t_preload();
      chan_en = 1'b0;
      preload(2'd0, 16'h1111);
      preload(2'd1, 16'h2222);
      preload(2'd2, 16'h3333);
      preload(2'd3, 16'h4444);
      chk("R4 load par", cnt_par, 16'h1111);
      chk("R4 load frm", cnt_frm, 16'h2222);
      chk("R4 load nos", cnt_nos, 16'h3333);
      chk("R4 load brk", cnt_brk, 16'h4444);
      chan_en = 1'b1;
      preload(2'd1, 16'hABCD);
      chk("R4 ignored when enabled", cnt_frm, 16'h2222);
   endtask

   task automatic t_break();
      clear_all();
      brk_irq_en = 1'b1; rx_irq_en = 1'b1; buf_open = 1'b0;
      send_bit(1'b1);
      send_char(8'h00, 1'b1, 1'b1, 1'b0);
      chk("R5 brk_irq", brk_irq, 1);
      chk("R5 cnt_brk", cnt_brk, 1);
      chk("R5 frm untouched", cnt_frm, 0);
      chk("R5 par untouched", cnt_par, 0);
      chk("R7 no close without buffer", buf_close, 0);
      chk("R7 no br without buffer", br_flag, 0);
      send_char(8'h00, 1'b0, 1'b1, 1'b0);
      chk("R6 long break irq", brk_irq, 0);
      chk("R6 long break count", cnt_brk, 1);
      send_bit(1'b0);
      send_char(8'h00, 1'b0, 1'b1, 1'b0);
      chk("R6 zero level keeps disarmed", cnt_brk, 1);
      send_bit(1'b1);
      buf_open = 1'b1;
      send_char(8'h00, 1'b0, 1'b1, 1'b0);
      chk("R7 close", buf_close, 1);
      chk("R7 rx_irq", rx_irq, 1);
      chk("R7 br_flag set", br_flag, 1);
      chk("R6 rearmed count", cnt_brk, 2);
      send_char(8'h5A, 1'b0, 1'b0, 1'b0);
      chk("R7 br_flag cleared", br_flag, 0);
      buf_open = 1'b0;
   endtask

   task automatic t_gating();
      clear_all();
      chan_en = 1'b0;
      send_char(8'h33, 1'b1, 1'b1, 1'b1);
      chk("R11 disabled par", cnt_par, 0);
      chk("R11 disabled frm", cnt_frm, 0);
      send_char(8'h00, 1'b0, 1'b1, 1'b0);
      chk("R11 disabled brk", cnt_brk, 0);
      chan_en = 1'b1;
      brk_irq_en = 1'b0; rx_irq_en = 1'b0; buf_open = 1'b1;
      send_bit(1'b1);
      send_char(8'h00, 1'b0, 1'b1, 1'b0);
      chk("R11 brk_irq gated", brk_irq, 0);
      chk("R11 rx_irq gated", rx_irq, 0);
      chk("R11 close still", buf_close, 1);
      chk("R11 count still", cnt_brk, 1);
      buf_open = 1'b0; rx_irq_en = 1'b1;
   endtask

   task automatic t_idle();
      chan_en = 1'b1; rx_irq_en = 1'b1; buf_open = 1'b1;
      cfg_data8 = 1'b0; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; cfg_addr_bit = 1'b0;
      max_idl = 16'd1;
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(8);
      chk("R8 len9 early", 16'(n_close), 0);
      ones(1);
      chk("R9 close at len9", 16'(n_close), 1);
      chk("R9 rx_irq at len9", 16'(n_rx), 1);
      ones(9);
      chk("R9 saturated no repeat", 16'(n_close), 0);
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(5);
      send_bit(1'b0);
      ones(8);
      chk("R8 zero restarts run", 16'(n_close), 0);
      ones(1);
      chk("R8 close after restart", 16'(n_close), 1);
      cfg_data8 = 1'b1; cfg_par_en = 1'b1; cfg_stop2 = 1'b1; cfg_addr_bit = 1'b1;
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(12);
      chk("R8 len13 early", 16'(n_close), 0);
      ones(1);
      chk("R8 close at len13", 16'(n_close), 1);
      cfg_data8 = 1'b0; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; cfg_addr_bit = 1'b0;
      max_idl = 16'd2;
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(9);
      chk("R9 first of two", 16'(n_close), 0);
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(9);
      chk("R10 char cleared idle count", 16'(n_close), 0);
      ones(9);
      chk("R9 second of two", 16'(n_close), 1);
      max_idl = 16'd0;
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(27);
      chk("R9 max zero disables", 16'(n_close), 0);
      max_idl = 16'd1; buf_open = 1'b0;
      send_char(8'h55, 1'b0, 1'b0, 1'b0);
      ones(9);
      chk("R9 no buffer no close", 16'(n_close), 0);
   endtask

   initial begin
      t_reset();
      t_err_counts();
      t_wrap();
      t_preload();
      t_break();
      t_gating();
      t_idle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule